// File: doc/BRIEF.md
# Multi-Block Transfer Reload Sequencer

This block manages the channel registers of one DMA channel across the blocks of a transfer. A transfer has one or more blocks. When the data engine reports that a block has finished, the sequencer decides how each register is set up for the next block, then starts that block. It handles four registers: the source address, the destination address, the control word and the next-descriptor pointer.

Each register has its own update method, chosen when the channel is started. An address register can take a word from an in-memory descriptor, return to the value it had at start, or carry on from the address where the previous block ended. The control word can take a descriptor word or return to its start value. The pointer changes only through descriptor fetches.

When any register uses descriptors, the transfer is chained. In a chained transfer, a five-word descriptor is read through a request/valid port before each new block, and a pointer value of zero marks the final block. In a transfer without chaining, a last-block input ends the transfer. The data engine itself is outside this block. It is modelled by a block-done pulse and the end addresses of the block.

Top module: `dmx_reload_seq`

## Requirements
- R1: Method codes are 0 = contiguous, 1 = reload, 2 = descriptor, and 3 = reserved. On a start, the configuration is illegal if the source or destination code is 3, or if the control code is 0 or 3. An illegal start sets `cfg_err_o`, and no block runs. A legal start clears `cfg_err_o`.
- R2: A legal start, accepted while idle or done, loads the four initial values and saves copies of the source, destination and control values. `blk_active_o` goes high on the next cycle.
- R3: An address register using contiguous mode takes, for the next block, the end address that was presented with that register's block-done pulse.
- R4: A register using reload mode takes, for the next block, the value it was loaded with at start. Later changes on the initial-value inputs have no effect.
- R5: In a chained transfer, each block boundary reads exactly five words, at the pointer plus 0, 4, 8, 12 and 16. The words are, in order: source, destination, next pointer, control low half, control high half. Only registers in descriptor mode take their word. The read holds while `fetch_vld_i` is low.
- R6: The pointer output changes only in a chained transfer. Without chaining, it keeps its start value for the whole transfer.
- R7: In a chained transfer, a block-done pulse while the pointer is zero ends the transfer, and the last-block input is ignored. Without chaining, a block-done pulse with the last-block input high ends the transfer. A zero pointer does not end it. When the transfer ends, `xfer_done_o` rises and `blk_active_o` falls.
- R8: After a non-final block-done, `blk_active_o` stays low until every register update is finished, including all descriptor reads. It is never high while a read is requested.
- R9: A start pulse while a transfer is running has no effect on the registers or the state.
- R10: After reset, all register outputs are zero, and no block, done, error or read request is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse (enables the channel) |
| src_method_i | input | 2 | Source address update method |
| dst_method_i | input | 2 | Destination address update method |
| ctl_method_i | input | 2 | Control word update method |
| init_src_i | input | W | Initial source address |
| init_dst_i | input | W | Initial destination address |
| init_ctl_i | input | 2W | Initial control word |
| init_ptr_i | input | W | Initial descriptor pointer |
| blk_done_i | input | 1 | Data engine finished the current block |
| last_blk_i | input | 1 | Final block marker, used only without chaining |
| src_end_i | input | W | Source address where the block ended |
| dst_end_i | input | W | Destination address where the block ended |
| fetch_req_o | output | 1 | Descriptor word read request |
| fetch_addr_o | output | W | Address of the requested descriptor word |
| fetch_vld_i | input | 1 | Read data valid |
| fetch_data_i | input | W | Read data |
| blk_active_o | output | 1 | A block is in progress |
| xfer_done_o | output | 1 | Transfer finished |
| cfg_err_o | output | 1 | Last start was rejected |
| cur_src_o | output | W | Current source address |
| cur_dst_o | output | W | Current destination address |
| cur_ctl_o | output | 2W | Current control word |
| cur_ptr_o | output | W | Current descriptor pointer |

## Verification
The hardest case to reach from the ports is a descriptor read that stalls part-way through. Every other word request is answered with `fetch_vld_i` low, so the word index must hold through idle cycles. A wrong address then returns a wrong descriptor word.

The bench sweeps all 64 method combinations. Each legal combination runs a three-block transfer. In chained runs, the last-block input is held high so that only the zero pointer can end them. In the second block of each run, a start pulse is sent with corrupted initial values, which exercises both the ignored start and the saved reload copies.

// File: rtl/dmx_reload_pkg.sv
package dmx_reload_pkg;

    typedef enum logic [1:0] {
        M_CONT   = 2'd0,
        M_RELOAD = 2'd1,
        M_LLIST  = 2'd2,
        M_RSVD   = 2'd3
    } method_e;

    typedef struct packed {
        method_e src;
        method_e dst;
        method_e ctl;
    } methods_t;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_RUN    = 3'd1,
        S_UPDATE = 3'd2,
        S_FETCH  = 3'd3,
        S_DONE   = 3'd4
    } seq_state_e;

    localparam int DESC_WORDS = 5;
    localparam int DI_SRC     = 0;
    localparam int DI_DST     = 1;
    localparam int DI_PTR     = 2;
    localparam int DI_CTL_LO  = 3;
    localparam int DI_CTL_HI  = 4;

    function automatic logic methods_legal(input methods_t m);
        return (m.src != M_RSVD) && (m.dst != M_RSVD) &&
               ((m.ctl == M_RELOAD) || (m.ctl == M_LLIST));
    endfunction

    function automatic logic uses_chain(input methods_t m);
        return (m.src == M_LLIST) || (m.dst == M_LLIST) || (m.ctl == M_LLIST);
    endfunction

endpackage

// File: rtl/dmx_seq_ctrl.sv
module dmx_seq_ctrl
    import dmx_reload_pkg::*;
#(
    parameter int NW = DESC_WORDS,
    localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          legal_i,
    input  logic          blk_done_i,
    input  logic          last_blk_i,
    input  logic          chain_i,
    input  logic          ptr_zero_i,
    input  logic          fetch_vld_i,
    output logic          load_o,
    output logic          capture_o,
    output logic          fetch_req_o,
    output logic          fetch_wr_o,
    output logic [IW-1:0] fetch_idx_o,
    output logic          apply_o,
    output logic          active_o,
    output logic          done_o,
    output logic          err_o
);

    seq_state_e    state_q, state_d;
    logic [IW-1:0] idx_q;
    logic          idle_like;
    logic          finish;
    logic          last_word;

    assign idle_like   = (state_q == S_IDLE) || (state_q == S_DONE);
    assign load_o      = idle_like && start_i && legal_i;
    assign capture_o   = (state_q == S_RUN) && blk_done_i;
    assign finish      = chain_i ? ptr_zero_i : last_blk_i;
    assign fetch_req_o = (state_q == S_FETCH);
    assign fetch_wr_o  = (state_q == S_FETCH) && fetch_vld_i;
    assign fetch_idx_o = idx_q;
    assign last_word   = (idx_q == IW'(NW - 1));
    assign apply_o     = (state_q == S_UPDATE);
    assign active_o    = (state_q == S_RUN);
    assign done_o      = (state_q == S_DONE);

    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE, S_DONE: if (start_i && legal_i) state_d = S_RUN;
            S_RUN: begin
                if (blk_done_i) begin
                    if (finish)       state_d = S_DONE;
                    else if (chain_i) state_d = S_FETCH;
                    else              state_d = S_UPDATE;
                end
            end
            S_FETCH:  if (fetch_vld_i && last_word) state_d = S_UPDATE;
            S_UPDATE: state_d = S_RUN;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            err_o   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (fetch_wr_o)
                idx_q <= last_word ? '0 : idx_q + 1'b1;
            if (idle_like && start_i)
                err_o <= !legal_i;
        end
    end

    // R1: a rejected configuration never runs a block
    assert_err_blocks_run_R1: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !active_o);

    // R5: word index stays inside the descriptor
    assert_idx_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        idx_q <= IW'(NW - 1));

    // R8: a block is entered only from a finished update or from a start
    assert_run_after_update_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_FETCH) |=> (state_q == S_FETCH || state_q == S_UPDATE));

    // R9: start has no effect while a block runs
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RUN && !blk_done_i) |=> (state_q == S_RUN));

endmodule

// File: rtl/dmx_chan_regs.sv
module dmx_chan_regs
    import dmx_reload_pkg::*;
#(
    parameter int W  = 32,
    parameter int NW = DESC_WORDS,
    localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  methods_t      methods_i,
    input  logic [W-1:0]  init_src_i,
    input  logic [W-1:0]  init_dst_i,
    input  logic [2*W-1:0] init_ctl_i,
    input  logic [W-1:0]  init_ptr_i,
    input  logic          capture_i,
    input  logic [W-1:0]  src_end_i,
    input  logic [W-1:0]  dst_end_i,
    input  logic          fetch_wr_i,
    input  logic [IW-1:0] fetch_idx_i,
    input  logic [W-1:0]  fetch_data_i,
    input  logic          apply_i,
    output logic [W-1:0]  cur_src_o,
    output logic [W-1:0]  cur_dst_o,
    output logic [2*W-1:0] cur_ctl_o,
    output logic [W-1:0]  cur_ptr_o,
    output logic          chain_o,
    output logic          ptr_zero_o
);

    methods_t       methods_q;
    logic [W-1:0]   stg_q   [NW];
    logic [W-1:0]   addr_q  [2];
    logic [W-1:0]   addr0_q [2];
    logic [W-1:0]   end_q   [2];
    logic [W-1:0]   init_a  [2];
    logic [W-1:0]   end_a   [2];
    method_e        meth_a  [2];
    logic [2*W-1:0] ctl_q, ctl0_q;
    logic [W-1:0]   ptr_q;

    assign init_a[0] = init_src_i;
    assign init_a[1] = init_dst_i;
    assign end_a[0]  = src_end_i;
    assign end_a[1]  = dst_end_i;
    assign meth_a[0] = methods_q.src;
    assign meth_a[1] = methods_q.dst;

    always_ff @(posedge clk) begin
        if (rst)         methods_q <= '0;
        else if (load_i) methods_q <= methods_i;
    end

    for (genvar k = 0; k < NW; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stg_q[k] <= '0;
            else if (fetch_wr_i && fetch_idx_i == IW'(k))
                stg_q[k] <= fetch_data_i;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_addr
        always_ff @(posedge clk) begin
            if (rst) begin
                addr_q[g]  <= '0;
                addr0_q[g] <= '0;
                end_q[g]   <= '0;
            end else if (load_i) begin
                addr_q[g]  <= init_a[g];
                addr0_q[g] <= init_a[g];
            end else begin
                if (capture_i)
                    end_q[g] <= end_a[g];
                if (apply_i) begin
                    case (meth_a[g])
                        M_CONT:   addr_q[g] <= end_q[g];
                        M_RELOAD: addr_q[g] <= addr0_q[g];
                        M_LLIST:  addr_q[g] <= stg_q[(g == 0) ? DI_SRC : DI_DST];
                        default:  addr_q[g] <= addr_q[g];
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            ctl0_q <= '0;
            ptr_q  <= '0;
        end else if (load_i) begin
            ctl_q  <= init_ctl_i;
            ctl0_q <= init_ctl_i;
            ptr_q  <= init_ptr_i;
        end else if (apply_i) begin
            if (methods_q.ctl == M_LLIST)
                ctl_q <= {stg_q[DI_CTL_HI], stg_q[DI_CTL_LO]};
            else if (methods_q.ctl == M_RELOAD)
                ctl_q <= ctl0_q;
            if (chain_o)
                ptr_q <= stg_q[DI_PTR];
        end
    end

    assign cur_src_o  = addr_q[0];
    assign cur_dst_o  = addr_q[1];
    assign cur_ctl_o  = ctl_q;
    assign cur_ptr_o  = ptr_q;
    assign chain_o    = uses_chain(methods_q);
    assign ptr_zero_o = (ptr_q == '0);

    // R6: pointer only moves when chaining or on a start
    assert_ptr_held_R6: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !chain_o) |=> $stable(ptr_q));

    // R4: reload restores the value saved at start
    assert_src_reload_R4: assert property (@(posedge clk) disable iff (rst)
        (apply_i && !load_i && methods_q.src == M_RELOAD) |=> (addr_q[0] == $past(addr0_q[0])));

    // R3: contiguous continues from the captured end address
    assert_dst_cont_R3: assert property (@(posedge clk) disable iff (rst)
        (apply_i && !load_i && methods_q.dst == M_CONT) |=> (addr_q[1] == $past(end_q[1])));

endmodule

// File: rtl/dmx_reload_seq.sv
module dmx_reload_seq
    import dmx_reload_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [1:0]     src_method_i,
    input  logic [1:0]     dst_method_i,
    input  logic [1:0]     ctl_method_i,
    input  logic [W-1:0]   init_src_i,
    input  logic [W-1:0]   init_dst_i,
    input  logic [2*W-1:0] init_ctl_i,
    input  logic [W-1:0]   init_ptr_i,
    input  logic           blk_done_i,
    input  logic           last_blk_i,
    input  logic [W-1:0]   src_end_i,
    input  logic [W-1:0]   dst_end_i,
    output logic           fetch_req_o,
    output logic [W-1:0]   fetch_addr_o,
    input  logic           fetch_vld_i,
    input  logic [W-1:0]   fetch_data_i,
    output logic           blk_active_o,
    output logic           xfer_done_o,
    output logic           cfg_err_o,
    output logic [W-1:0]   cur_src_o,
    output logic [W-1:0]   cur_dst_o,
    output logic [2*W-1:0] cur_ctl_o,
    output logic [W-1:0]   cur_ptr_o
);

    localparam int NW       = DESC_WORDS;
    localparam int IW       = $clog2(NW);
    localparam int BYTE_SH  = $clog2(W / 8);

    methods_t      cfg_m;
    logic          legal;
    logic          load, capture, fetch_wr, apply;
    logic          chain, ptr_zero;
    logic [IW-1:0] fetch_idx;

    assign cfg_m = '{src: method_e'(src_method_i),
                     dst: method_e'(dst_method_i),
                     ctl: method_e'(ctl_method_i)};
    assign legal = methods_legal(cfg_m);

    dmx_seq_ctrl #(.NW(NW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .legal_i     (legal),
        .blk_done_i  (blk_done_i),
        .last_blk_i  (last_blk_i),
        .chain_i     (chain),
        .ptr_zero_i  (ptr_zero),
        .fetch_vld_i (fetch_vld_i),
        .load_o      (load),
        .capture_o   (capture),
        .fetch_req_o (fetch_req_o),
        .fetch_wr_o  (fetch_wr),
        .fetch_idx_o (fetch_idx),
        .apply_o     (apply),
        .active_o    (blk_active_o),
        .done_o      (xfer_done_o),
        .err_o       (cfg_err_o)
    );

    dmx_chan_regs #(.W(W), .NW(NW)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load),
        .methods_i    (cfg_m),
        .init_src_i   (init_src_i),
        .init_dst_i   (init_dst_i),
        .init_ctl_i   (init_ctl_i),
        .init_ptr_i   (init_ptr_i),
        .capture_i    (capture),
        .src_end_i    (src_end_i),
        .dst_end_i    (dst_end_i),
        .fetch_wr_i   (fetch_wr),
        .fetch_idx_i  (fetch_idx),
        .fetch_data_i (fetch_data_i),
        .apply_i      (apply),
        .cur_src_o    (cur_src_o),
        .cur_dst_o    (cur_dst_o),
        .cur_ctl_o    (cur_ctl_o),
        .cur_ptr_o    (cur_ptr_o),
        .chain_o      (chain),
        .ptr_zero_o   (ptr_zero)
    );

    assign fetch_addr_o = cur_ptr_o + (W'(fetch_idx) << BYTE_SH);

    // R8: no block runs while a descriptor read is outstanding
    assert_no_run_while_fetch_R8: assert property (@(posedge clk) disable iff (rst)
        fetch_req_o |-> !blk_active_o);

    // R7: completion and activity are exclusive
    assert_done_excl_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_done_o) |-> !blk_active_o && $past(blk_active_o));

endmodule

// File: tb/dmx_reload_seq_test.sv
`timescale 1ns/1ps
module dmx_reload_seq_test;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic           start_i = 0, blk_done_i = 0, last_blk_i = 0;
    logic [1:0]     src_m = 0, dst_m = 0, ctl_m = 0;
    logic [W-1:0]   init_src = 0, init_dst = 0, init_ptr = 0;
    logic [2*W-1:0] init_ctl = 0;
    logic [W-1:0]   src_end = 0, dst_end = 0;
    logic           fetch_req, fetch_vld = 0;
    logic [W-1:0]   fetch_addr, fetch_data = 0;
    logic           blk_active, xfer_done, cfg_err;
    logic [W-1:0]   cur_src, cur_dst, cur_ptr;
    logic [2*W-1:0] cur_ctl;

    dmx_reload_seq #(.W(W)) uut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .src_method_i(src_m), .dst_method_i(dst_m), .ctl_method_i(ctl_m),
        .init_src_i(init_src), .init_dst_i(init_dst), .init_ctl_i(init_ctl), .init_ptr_i(init_ptr),
        .blk_done_i(blk_done_i), .last_blk_i(last_blk_i),
        .src_end_i(src_end), .dst_end_i(dst_end),
        .fetch_req_o(fetch_req), .fetch_addr_o(fetch_addr),
        .fetch_vld_i(fetch_vld), .fetch_data_i(fetch_data),
        .blk_active_o(blk_active), .xfer_done_o(xfer_done), .cfg_err_o(cfg_err),
        .cur_src_o(cur_src), .cur_dst_o(cur_dst), .cur_ctl_o(cur_ctl), .cur_ptr_o(cur_ptr)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] desc_word(input logic [W-1:0] addr);
        logic [W-1:0] base;
        logic [2:0]   k;
        base = {addr[W-1:5], 5'b0};
        k    = addr[4:2];
        if (k == 3'd2) return (base == 32'h100) ? 32'h200 : 32'h0;
        return 32'hA000_0000 | (base << 8) | W'(k);
    endfunction

    // descriptor memory with a stall on every other request cycle
    logic [W-1:0] exp_fbase = 0;
    int  wcnt = 0;
    bit  stall = 0;
    always @(negedge clk) begin
        if (fetch_req === 1'b1) begin
            check("R8 active during read", blk_active, 1'b0);
            if (!stall) begin
                check("R5 read address", fetch_addr, exp_fbase + W'(4 * wcnt));
                fetch_vld  = 1'b1;
                fetch_data = desc_word(fetch_addr);
                wcnt++;
            end else begin
                fetch_vld = 1'b0;
            end
            stall = !stall;
        end else begin
            fetch_vld = 1'b0;
            stall     = 1'b0;
        end
    end

    task automatic run_cfg(input int sm, input int dm, input int cm, input logic [W-1:0] p0);
        logic [W-1:0]   s0, d0, es, ed, ep;
        logic [2*W-1:0] c0, ec;
        logic [W-1:0]   w [5];
        bit legal, chain, fin;
        s0 = 32'h1000_0000 ^ W'((sm * 16 + dm * 4 + cm) << 4);
        d0 = 32'h2000_0000 ^ W'((sm * 16 + dm * 4 + cm) << 4);
        c0 = {32'h4000_0000 | W'(cm), 32'h3000_0000 | W'(sm)};
        @(negedge clk);
        src_m = 2'(sm); dst_m = 2'(dm); ctl_m = 2'(cm);
        init_src = s0; init_dst = d0; init_ctl = c0; init_ptr = p0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        legal = (sm != 3) && (dm != 3) && (cm == 1 || cm == 2);
        chain = (sm == 2) || (dm == 2) || (cm == 2);
        check("R1 error flag", cfg_err, !legal);
        check("R2 block starts", blk_active, legal);
        if (!legal) return;
        es = s0; ed = d0; ec = c0; ep = p0;
        for (int n = 1; n <= 3; n++) begin
            check("R2/R3/R4/R5 src", cur_src, es);
            check("R2/R3/R4/R5 dst", cur_dst, ed);
            check("R2/R4/R5 ctl", cur_ctl, ec);
            check("R2/R5/R6 ptr", cur_ptr, ep);
            if (n == 2) begin
                init_src = ~s0; init_dst = ~d0; init_ctl = ~c0; init_ptr = ~p0;
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                check("R9 still active", blk_active, 1'b1);
                check("R9 src unchanged", cur_src, es);
                check("R9 ptr unchanged", cur_ptr, ep);
            end
            blk_done_i = 1'b1;
            src_end    = es + 32'h40;
            dst_end    = ed + 32'h80;
            last_blk_i = chain ? 1'b1 : (n == 3);
            exp_fbase  = ep;
            wcnt       = 0;
            @(negedge clk);
            blk_done_i = 1'b0;
            last_blk_i = 1'b0;
            fin = chain ? (ep == 0) : (n == 3);
            if (fin) begin
                check("R7 done raised", xfer_done, 1'b1);
                check("R7 block low", blk_active, 1'b0);
                break;
            end
            check("R8 gap after block", blk_active, 1'b0);
            for (int t = 0; t < 40 && blk_active !== 1'b1; t++) @(negedge clk);
            check("R5 words read", 32'(wcnt), chain ? 32'd5 : 32'd0);
            check("R7 not done early", xfer_done, 1'b0);
            for (int k = 0; k < 5; k++) w[k] = desc_word(ep + W'(4 * k));
            es = (sm == 0) ? es + 32'h40 : (sm == 1) ? s0 : w[0];
            ed = (dm == 0) ? ed + 32'h80 : (dm == 1) ? d0 : w[1];
            ec = (cm == 1) ? c0 : {w[4], w[3]};
            if (chain) ep = w[2];
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R10 active", blk_active, 1'b0);
        check("R10 done", xfer_done, 1'b0);
        check("R10 err", cfg_err, 1'b0);
        check("R10 read req", fetch_req, 1'b0);
        check("R10 regs", {cur_src, cur_dst, cur_ptr}, '0);
        check("R10 ctl", cur_ctl, '0);
        rst = 1'b0;
        for (int sm = 0; sm < 4; sm++)
            for (int dm = 0; dm < 4; dm++)
                for (int cm = 0; cm < 4; cm++) begin
                    logic [W-1:0] p;
                    if (sm == 2 || dm == 2 || cm == 2) p = 32'h100;
                    else p = ((sm + dm) % 2 == 1) ? 32'h0 : 32'h55AA_0000;
                    run_cfg(sm, dm, cm, p);
                end
        // chained transfer whose start pointer is zero: one block only
        run_cfg(2, 1, 1, 32'h0);
        // rejected start after a finished transfer
        run_cfg(0, 0, 0, 32'h100);
        check("R1 no block after reject", blk_active, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule